// File: doc/BRIEF.md
# SD Card Command Issue Engine

This block lets software send one command at a time to an SD card over the single-bit command line. Software first sets the card clock ratio, then loads a 32-bit argument. It then writes a command index to the launch register. The engine builds a 48-bit command frame and appends a CRC7 checksum. It shifts the frame out against a card clock that it derives from the system clock, then listens for the card's reply. A 32-bit word taken from that reply, together with a small flag register, tells software how the command ended.

Only a fixed set of command indices is accepted, and each index has its own reply class. Index 0 gets no reply. Index 2 gets a 136-bit reply. Indices 3, 7, 12 and 41 get a 48-bit reply. Any other value written to the launch register is refused. Data transfers on the data lines and the card bring-up sequence belong to other logic.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset, the flag register (address 4) and the card word register (address 3) read 0, `cmd_oe` is 0, `cmd_out` is 1 and the clock ratio is 2.
- R2: `sd_clk` has a period of P system clocks, where P is the last value of 2 or more written to address 0. A write of 0 or 1 to address 0 leaves P unchanged.
- R3: A launch drives exactly 48 bits on `cmd_out` with `cmd_oe` high, MSB first, in this order: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument from address 1, CRC7 and a 1 end bit. `cmd_oe` is 0 whenever the engine is idle.
- R4: CRC7 uses the generator x^7+x^3+1 with a zero start value, computed over the first 40 frame bits. Index 0 with argument 0 therefore gives the frame 0x40_0000_0000_95.
- R5: `cmd_out` and `cmd_oe` change only at falling edges of `sd_clk`, and `cmd_in` is sampled at rising edges.
- R6: Index 0 expects no reply. The busy flag (flag bit 0) clears after the end bit is sent.
- R7: For indices 3, 7, 12 and 41, the engine takes a 48-bit reply that begins with a 0 start bit on `cmd_in`. The card word (address 3) becomes reply bits 8 to 39, counted from the start bit as bit 0 and taken MSB first. Busy clears after the last reply bit.
- R8: For index 2 the reply is 136 bits long. The card word is taken from the same bits 8 to 39, and busy stays set until all 136 bits are in.
- R9: If no start bit arrives within 64 rising `sd_clk` edges after the frame ends, busy clears and the timeout flag (flag bit 1) sets. The next accepted launch clears the timeout flag.
- R10: A launch value outside {0,2,3,7,12,41}, written while idle, starts nothing and sets the reject flag (flag bit 2). The next accepted launch clears the reject flag.
- R11: A write to the launch register while busy is ignored: no second frame is sent and the flags and the card word are not changed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 ratio, 1 argument, 2 launch, 3 card word, 4 flags |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (0 for write-only addresses) |
| sd_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Command line value driven to the card |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line value from the card |

## Verification
A wrong divider count shows within two card clock periods as a measured period that differs from P. A sequencer that is off by one bit corrupts the very next frame that the card model collects, or leaves the engine stuck busy. That second case is caught when the bench polls the busy flag. A bad capture window or a wrong reply length shows as a wrong card word right after busy drops, and a miscounted timeout shows as a missing timeout flag. A busy-time write that leaks through appears as an extra frame at the card, or as a changed card word.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_RATIO  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ARG    = 3'd1;
  localparam logic [ADDR_W-1:0] A_LAUNCH = 3'd2;
  localparam logic [ADDR_W-1:0] A_WORD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd4;

  localparam int unsigned FLG_BUSY = 0;
  localparam int unsigned FLG_TMO  = 1;
  localparam int unsigned FLG_REJ  = 2;

  typedef enum logic [1:0] {RSP_NONE, RSP_SHORT, RSP_LONG} rsp_e;

  function automatic logic idx_ok(input logic [31:0] v);
    case (v)
      32'd0, 32'd2, 32'd3, 32'd7, 32'd12, 32'd41: idx_ok = 1'b1;
      default: idx_ok = 1'b0;
    endcase
  endfunction

  function automatic rsp_e rsp_of(input logic [5:0] idx);
    case (idx)
      6'd0:    rsp_of = RSP_NONE;
      6'd2:    rsp_of = RSP_LONG;
      default: rsp_of = RSP_SHORT;
    endcase
  endfunction
endpackage

// File: rtl/sdcmd_clkdiv.sv
module sdcmd_clkdiv #(
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] ratio,
  output logic          sd_clk,
  output logic          rise_evt,
  output logic          fall_evt
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;
  logic [PW-1:0] half;

  always_comb begin
    half     = ratio >> 1;
    rise_evt = (cnt_q >= ratio - PW'(1));
    fall_evt = (cnt_q == half - PW'(1));
    cnt_d    = rise_evt ? '0 : cnt_q + PW'(1);
    sck_d    = sck_q;
    if (rise_evt)      sck_d = 1'b1;
    else if (fall_evt) sck_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sd_clk = sck_q;
endmodule

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
  parameter int unsigned DW = 40
) (
  input  logic [DW-1:0] data,
  output logic [6:0]    crc
);
  localparam logic [6:0] GEN = 7'h09;

  always_comb begin
    logic fb;
    crc = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      fb  = data[i] ^ crc[6];
      crc = {crc[5:0], 1'b0} ^ (fb ? GEN : 7'h00);
    end
  end
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int unsigned ARG_W      = 32,
  parameter int unsigned FRAME_BITS = 48,
  parameter int unsigned SHORT_BITS = 48,
  parameter int unsigned LONG_BITS  = 136,
  parameter int unsigned CAP_LO     = 8,
  parameter int unsigned TO_CLKS    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [5:0]       idx,
  input  logic [ARG_W-1:0] arg,
  input  logic [6:0]       crc,
  input  rsp_e             rsp,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             cmd_in,
  output logic             cmd_out,
  output logic             cmd_oe,
  output logic             busy,
  output logic             tmo,
  output logic [ARG_W-1:0] word
);
  localparam int unsigned CW = $clog2(LONG_BITS + 1);
  localparam int unsigned TW = $clog2(TO_CLKS);
  localparam logic [CW-1:0] C_FRAME = CW'(FRAME_BITS);
  localparam logic [CW-1:0] C_SHORT = CW'(SHORT_BITS - 1);
  localparam logic [CW-1:0] C_LONG  = CW'(LONG_BITS - 1);
  localparam logic [CW-1:0] C_CLO   = CW'(CAP_LO);
  localparam logic [CW-1:0] C_CHI   = CW'(CAP_LO + ARG_W);
  localparam logic [TW-1:0] T_LAST  = TW'(TO_CLKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_RECV} st_e;

  st_e                   st_q, st_d;
  logic [FRAME_BITS-1:0] frm_q, frm_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic [TW-1:0]         to_q, to_d;
  rsp_e                  rsp_q, rsp_d;
  logic [ARG_W-1:0]      cap_q, cap_d, word_q, word_d;
  logic                  out_q, out_d, oe_q, oe_d, tmo_q, tmo_d;
  logic [CW-1:0]         last_bit;

  always_comb begin
    st_d   = st_q;   frm_d  = frm_q;  cnt_d = cnt_q; to_d = to_q;
    rsp_d  = rsp_q;  cap_d  = cap_q;  word_d = word_q;
    out_d  = out_q;  oe_d   = oe_q;   tmo_d = tmo_q;
    last_bit = (rsp_q == RSP_LONG) ? C_LONG : C_SHORT;
    case (st_q)
      S_IDLE: if (start) begin
        frm_d = {1'b0, 1'b1, idx, arg, crc, 1'b1};
        rsp_d = rsp;
        cnt_d = '0;
        tmo_d = 1'b0;
        st_d  = S_SEND;
      end
      S_SEND: if (fall_evt) begin
        if (cnt_q == C_FRAME) begin
          oe_d  = 1'b0;
          out_d = 1'b1;
          to_d  = '0;
          st_d  = (rsp_q == RSP_NONE) ? S_IDLE : S_WAIT;
        end else begin
          oe_d  = 1'b1;
          out_d = frm_q[FRAME_BITS-1];
          frm_d = {frm_q[FRAME_BITS-2:0], 1'b0};
          cnt_d = cnt_q + CW'(1);
        end
      end
      S_WAIT: if (rise_evt) begin
        if (!cmd_in) begin
          cnt_d = CW'(1);
          st_d  = S_RECV;
        end else if (to_q == T_LAST) begin
          tmo_d = 1'b1;
          st_d  = S_IDLE;
        end else begin
          to_d = to_q + TW'(1);
        end
      end
      S_RECV: if (rise_evt) begin
        if (cnt_q >= C_CLO && cnt_q < C_CHI) cap_d = {cap_q[ARG_W-2:0], cmd_in};
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == last_bit) begin
          word_d = cap_q;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; frm_q <= '0; cnt_q <= '0; to_q <= '0;
      rsp_q <= RSP_NONE; cap_q <= '0; word_q <= '0;
      out_q <= 1'b1; oe_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      st_q <= st_d; frm_q <= frm_d; cnt_q <= cnt_d; to_q <= to_d;
      rsp_q <= rsp_d; cap_q <= cap_d; word_q <= word_d;
      out_q <= out_d; oe_q <= oe_d; tmo_q <= tmo_d;
    end
  end

  assign cmd_out = out_q;
  assign cmd_oe  = oe_q;
  assign busy    = (st_q != S_IDLE);
  assign tmo     = tmo_q;
  assign word    = word_q;
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int unsigned RATIO_W   = 16,
  parameter int unsigned RATIO_RST = 2,
  parameter int unsigned TO_CLKS   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sd_clk,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              cmd_in
);
  localparam logic [31:0] RATIO_MAX = 32'((64'd1 << RATIO_W) - 64'd1);

  logic               rst_meta, rst_s;
  logic [RATIO_W-1:0] period_q, period_d;
  logic [31:0]        arg_q, arg_d;
  logic               rej_q, rej_d;
  logic               launch_wr, launch_go;
  logic               busy_w, tmo_w, rise_w, fall_w;
  logic [6:0]         crc_w;
  logic [31:0]        word_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  always_comb begin
    launch_wr = reg_wr && (reg_addr == A_LAUNCH);
    launch_go = launch_wr && !busy_w && idx_ok(reg_wdata);
    period_d  = period_q;
    arg_d     = arg_q;
    rej_d     = rej_q;
    if (reg_wr && reg_addr == A_RATIO && reg_wdata >= 32'd2 && reg_wdata <= RATIO_MAX)
      period_d = reg_wdata[RATIO_W-1:0];
    if (reg_wr && reg_addr == A_ARG)
      arg_d = reg_wdata;
    if (launch_wr && !busy_w)
      rej_d = !idx_ok(reg_wdata);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      period_q <= RATIO_W'(RATIO_RST);
      arg_q    <= '0;
      rej_q    <= 1'b0;
    end else begin
      period_q <= period_d;
      arg_q    <= arg_d;
      rej_q    <= rej_d;
    end
  end

  sdcmd_clkdiv #(.PW(RATIO_W)) u_div (
    .clk(clk), .rst_n(rst_s), .ratio(period_q),
    .sd_clk(sd_clk), .rise_evt(rise_w), .fall_evt(fall_w)
  );

  sdcmd_crc7 #(.DW(40)) u_crc (
    .data({1'b0, 1'b1, reg_wdata[5:0], arg_q}), .crc(crc_w)
  );

  sdcmd_seq #(.ARG_W(32), .TO_CLKS(TO_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_s), .start(launch_go),
    .idx(reg_wdata[5:0]), .arg(arg_q), .crc(crc_w),
    .rsp(rsp_of(reg_wdata[5:0])),
    .rise_evt(rise_w), .fall_evt(fall_w), .cmd_in(cmd_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy_w),
    .tmo(tmo_w), .word(word_w)
  );

  always_comb begin
    case (reg_addr)
      A_WORD:  reg_rdata = word_w;
      A_FLAGS: reg_rdata = {29'd0, rej_q, tmo_w, busy_w};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk #(
  parameter int unsigned RATIO_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sd_clk,
  input logic               cmd_out,
  input logic               cmd_oe,
  input logic               busy,
  input logic               tmo,
  input logic               launch_wr,
  input logic [RATIO_W-1:0] period
);
  p_ratio_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    period >= RATIO_W'(2));

  p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out);

  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_oe);

  p_out_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_out) |-> $fell(sd_clk));

  p_oe_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_oe) |-> $fell(sd_clk));

  p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> !busy);

  p_busy_write_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_wr && busy && !$fell(sd_clk)) |=> busy);
endmodule

bind sdcmd_engine sdcmd_engine_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_clk(sd_clk), .cmd_out(cmd_out),
  .cmd_oe(cmd_oe), .busy(busy_w), .tmo(tmo_w),
  .launch_wr(launch_wr), .period(period_q)
);

// File: tb/sdcmd_engine_test.sv
module sdcmd_engine_test;
  localparam time CLK_PERIOD = 10;

  logic        clk, rst_n, reg_wr, cmd_in;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sd_clk, cmd_out, cmd_oe;

  int checks = 0, errors = 0, frames_seen = 0;
  logic [47:0] exp_frames[$];
  logic [47:0] last_rx;
  bit    card_silent = 0;
  int    card_delay  = 2;
  logic [31:0] card_word = 32'h0;
  time   last_fall = 0;
  bit    done = 0;

  sdcmd_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_clk(sd_clk),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] bcrc(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] f;
    int n = 0;
    rd(3'd4, f);
    while (f[0] && n < 5000) begin
      rd(3'd4, f);
      n++;
    end
    check(!f[0], req, f, 0);
  endtask

  task automatic launch(input logic [5:0] idx, input logic [31:0] arg, input bit expect_frame);
    logic [39:0] h;
    h = {2'b01, idx, arg};
    if (expect_frame) exp_frames.push_back({h, bcrc(h), 1'b1});
    wr(3'd1, arg);
    wr(3'd2, {26'd0, idx});
  endtask

  task automatic measure(output time p);
    time t0;
    repeat (2) @(posedge sd_clk);
    t0 = $time;
    @(posedge sd_clk);
    p = $time - t0;
  endtask

  // Card model and scoreboard monitor: samples on rising sd_clk (R5)
  initial begin
    logic [47:0] rx;
    logic [135:0] rv;
    logic [47:0] s;
    int n, len;
    cmd_in = 1;
    n = 0;
    rx = '0;
    forever begin
      @(posedge sd_clk);
      if (cmd_oe) begin
        rx = {rx[46:0], cmd_out};
        n++;
        if (n == 48) begin
          n = 0;
          frames_seen++;
          last_rx = rx;
          if (exp_frames.size() == 0) check(0, "R3 unexpected frame", rx, 0);
          else begin
            logic [47:0] e;
            e = exp_frames.pop_front();
            check(rx == e, "R3 frame", rx, e);
          end
          len = 0;
          if (!card_silent && rx[45:40] == 6'd2) begin
            len = 136;
            rv = {2'b00, 6'h3F, card_word, 95'h5A5A, 1'b1};
          end else if (!card_silent && rx[45:40] != 6'd0) begin
            len = 48;
            s = {2'b00, rx[45:40], card_word, bcrc({2'b00, rx[45:40], card_word}), 1'b1};
            rv = {s, 88'd0};
          end
          if (len > 0) begin
            repeat (card_delay) @(negedge sd_clk);
            for (int i = 0; i < len; i++) begin
              @(negedge sd_clk);
              #1 cmd_in = rv[135 - i];
            end
            @(negedge sd_clk);
            #1 cmd_in = 1;
          end
        end
      end
    end
  end

  initial forever begin
    @(negedge sd_clk);
    last_fall = $time;
  end

  // R5: every change of cmd_out coincides with a falling sd_clk edge
  initial forever begin
    time t;
    @(cmd_out);
    t = $time;
    #1;
    if (rst_n && t > 0) check(last_fall == t, "R5 cmd_out edge", t, last_fall);
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    time p;
    int f0;
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd4, v); check(v == 0, "R1 flags", v, 0);
    rd(3'd3, v); check(v == 0, "R1 card word", v, 0);
    check(cmd_oe == 0 && cmd_out == 1, "R1 line idle", {cmd_oe, cmd_out}, 2'b01);
    measure(p); check(p == 2 * CLK_PERIOD, "R1 default ratio", p, 2 * CLK_PERIOD);

    // R2 divider
    wr(3'd0, 5); measure(p); check(p == 5 * CLK_PERIOD, "R2 ratio 5", p, 5 * CLK_PERIOD);
    wr(3'd0, 1); measure(p); check(p == 5 * CLK_PERIOD, "R2 ratio 1 ignored", p, 5 * CLK_PERIOD);
    wr(3'd0, 0); measure(p); check(p == 5 * CLK_PERIOD, "R2 ratio 0 ignored", p, 5 * CLK_PERIOD);
    wr(3'd0, 3); measure(p); check(p == 3 * CLK_PERIOD, "R2 ratio 3", p, 3 * CLK_PERIOD);

    // R4 / R6 index 0, no reply
    launch(6'd0, 32'h0, 1);
    rd(3'd4, v); check(v[0] == 1, "R6 busy after launch", v, 1);
    wait_idle("R6 idle");
    check(last_rx == 48'h40_0000_0000_95, "R4 crc frame", last_rx, 48'h40_0000_0000_95);
    rd(3'd4, v); check(v == 0, "R6 flags", v, 0);
    check(exp_frames.size() == 0, "R3 frame sent", exp_frames.size(), 0);

    // R7 short replies
    card_word = 32'h1234_0000; card_delay = 2;
    launch(6'd3, 32'h0, 1); wait_idle("R7 idle 3");
    rd(3'd3, v); check(v == 32'h1234_0000, "R7 word idx3", v, 32'h1234_0000);
    card_word = 32'h0000_0900; card_delay = 7;
    launch(6'd7, 32'h1234_0000, 1); wait_idle("R7 idle 7");
    rd(3'd3, v); check(v == 32'h0000_0900, "R7 word idx7", v, 32'h0000_0900);
    card_word = 32'hA5C3_0F81; card_delay = 0;
    launch(6'd12, 32'h1234_0000, 1); wait_idle("R7 idle 12");
    rd(3'd3, v); check(v == 32'hA5C3_0F81, "R7 word idx12", v, 32'hA5C3_0F81);
    card_word = 32'h80FF_8000; card_delay = 3;
    launch(6'd41, 32'h40FF_8000, 1); wait_idle("R7 idle 41");
    rd(3'd3, v); check(v == 32'h80FF_8000, "R7 word idx41", v, 32'h80FF_8000);
    rd(3'd4, v); check(v == 0, "R7 flags", v, 0);

    // R8 long reply: still busy once a short reply would have finished
    card_word = 32'hCAFE_F00D; card_delay = 2;
    launch(6'd2, 32'h0, 1);
    wait (frames_seen == 6);
    repeat (2 + 60) @(posedge sd_clk);
    rd(3'd4, v); check(v[0] == 1, "R8 busy past 48 bits", v, 1);
    wait_idle("R8 idle");
    rd(3'd3, v); check(v == 32'hCAFE_F00D, "R8 word idx2", v, 32'hCAFE_F00D);

    // R9 timeout
    card_silent = 1;
    launch(6'd3, 32'h0, 1); wait_idle("R9 idle");
    rd(3'd4, v); check(v == 32'h2, "R9 timeout flag", v, 2);
    rd(3'd3, v); check(v == 32'hCAFE_F00D, "R9 word kept", v, 32'hCAFE_F00D);
    card_silent = 0; card_word = 32'h0000_0500;
    launch(6'd3, 32'h0, 1); wait_idle("R9 idle 2");
    rd(3'd4, v); check(v == 0, "R9 timeout cleared", v, 0);

    // R10 rejected indices
    f0 = frames_seen;
    wr(3'd2, 32'd8);
    rd(3'd4, v); check(v == 32'h4, "R10 reject idx8", v, 4);
    wr(3'd2, 32'd67);
    rd(3'd4, v); check(v == 32'h4, "R10 reject 67", v, 4);
    repeat (200) @(negedge clk);
    check(frames_seen == f0, "R10 no frame", frames_seen, f0);
    card_word = 32'h0000_0700;
    launch(6'd3, 32'h0, 1); wait_idle("R10 idle");
    rd(3'd4, v); check(v == 0, "R10 reject cleared", v, 0);

    // R11 launch while busy ignored
    f0 = frames_seen;
    card_word = 32'h3333_0000;
    launch(6'd3, 32'h0, 1);
    wr(3'd1, 32'h7777_0000);
    wr(3'd2, 32'd99);
    wr(3'd2, 32'd7);
    rd(3'd4, v); check(v == 1, "R11 flags while busy", v, 1);
    wait_idle("R11 idle");
    repeat (400) @(negedge clk);
    check(frames_seen == f0 + 1, "R11 one frame", frames_seen, f0 + 1);
    rd(3'd3, v); check(v == 32'h3333_0000, "R11 word", v, 32'h3333_0000);
    rd(3'd4, v); check(v == 0, "R11 flags after", v, 0);
    check(exp_frames.size() == 0, "R3 queue drained", exp_frames.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule